// File: doc/BRIEF.md
# Programmable Interval Timer with Register Port

This block is a 32-bit down-counter that software controls through a small register port of four 32-bit words. Software loads a period value, which lands both in a holding register and directly in the live counter. It then issues start or stop commands through self-clearing bits of the control word, and chooses between a single run and automatic reload. The counter moves only on cycles where the tick-enable input is high, so an external prescaler sets the count rate.

When the count runs out, a sticky timeout flag is set. If the interrupt enable is on, that flag drives a level interrupt. Software acknowledges the timeout by writing anything at all to the status word. A read-only snapshot word returns the live count at any time. Reads complete one cycle after the request, and a read-valid strobe marks the returned data.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped, the snapshot reads 0 and irq_o is low.
- R2: A write to offset 0x8 stores the period and loads the same value into the live counter in that cycle. Reads of 0x8 and of 0xC then both return it.
- R3: While running, the counter drops by exactly one on each cycle with tick_en_i high. It holds its value when tick_en_i is low or the timer is stopped.
- R4: Expiry is a tick taken at count 1 or count 0. It sets status bit 0 (timeout). In one-shot mode (control bit 1 clear) the count ends at 0 and status bit 1 (running) clears.
- R5: In auto-reload mode (control bit 1 set), expiry reloads the counter from the period register and the timer keeps running. A period of 0 therefore expires on every tick.
- R6: Control bit 2 starts the counter and control bit 3 stops it. When both are set in the same write, stop wins. The command bits read back as 0, while bits 0 and 1 read back as written. Status bit 1 shows the live run state and cannot be written.
- R7: Any write to offset 0x0 clears the timeout flag, whatever the data. If an expiry falls in the same cycle, the flag stays set.
- R8: irq_o is high exactly when the timeout flag and control bit 0 (interrupt enable) are both set.
- R9: A read request returns its data on rd_data_o with rd_valid_o high one cycle later. The data reflects state at the request cycle. rd_valid_o is low in every other cycle.
- R10: Writes to 0xC, to offsets at or above 0x10, or to misaligned addresses change nothing. Reads of such unmapped addresses return zero.
- R11: A period write that coincides with a counting tick leaves the counter at the written value, not the decremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Count-enable strobe from the rate source |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the word |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle: a software acknowledge of the timeout can coincide with a hardware expiry, and a period write can coincide with a counting tick. The bench sets up each collision by first ticking the counter down to 1, or to a known value. It then raises tick_en_i in the very cycle that carries the status or period write. The status word must still show the timeout. The snapshot must show the written period rather than a decremented one.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_STATUS   = 2'd0,
    SEL_CONTROL  = 2'd1,
    SEL_PERIOD   = 2'd2,
    SEL_SNAPSHOT = 2'd3
  } reg_sel_e;

  localparam int ST_TIMEOUT_BIT  = 0;
  localparam int ST_RUNNING_BIT  = 1;
  localparam int CT_IRQ_EN_BIT   = 0;
  localparam int CT_RELOAD_BIT   = 1;
  localparam int CT_START_BIT    = 2;
  localparam int CT_STOP_BIT     = 3;

  typedef struct packed {
    logic auto_reload;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         auto_reload_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         step;

  assign step     = run_q & tick_en_i;
  // tick at 1 or 0 ends the run; 0 covers a zero period
  assign expire_o = step & (cnt_q <= W'(1));
  assign count_o  = cnt_q;
  assign running_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (load_i)        cnt_q <= load_val_i;
      else if (expire_o) cnt_q <= auto_reload_i ? period_i : '0;
      else if (step)     cnt_q <= cnt_q - W'(1);

      if (stop_i)                           run_q <= 1'b0;
      else if (start_i)                     run_q <= 1'b1;
      else if (expire_o && !auto_reload_i)  run_q <= 1'b0;
    end
  end

  assert_stop_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_o);

  assert_dec_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && tick_en_i && count_o > W'(1) && !load_i) |=> count_o == $past(count_o) - W'(1));

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !load_i) |=> $stable(count_o));

  assert_oneshot_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !auto_reload_i && !start_i && !load_i) |=> (!running_o && count_o == '0));
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [W-1:0]      req_wdata_i,
  input  logic              expire_i,
  input  logic              running_i,
  input  logic [W-1:0]      count_i,
  output ctrl_t             ctrl_o,
  output logic [W-1:0]      period_o,
  output logic              load_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              timeout_o,
  output logic              rd_valid_o,
  output logic [W-1:0]      rd_data_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic        mapped;
  reg_sel_e    sel;
  logic        wr_hit, rd_hit;
  ctrl_t       ctrl_q;
  logic [W-1:0] period_q;
  logic        timeout_q;
  logic [W-1:0] rd_mux;

  generate
    if (WORD_W > 2) begin : g_wide
      assign mapped = ~|req_addr_i[ADDR_W-1:4] & ~|req_addr_i[1:0];
    end else begin : g_narrow
      assign mapped = ~|req_addr_i[1:0];
    end
  endgenerate

  assign sel    = reg_sel_e'(req_addr_i[3:2]);
  assign wr_hit = req_valid_i & req_write_i & mapped;
  assign rd_hit = req_valid_i & ~req_write_i;

  assign load_o  = wr_hit & (sel == SEL_PERIOD);
  assign start_o = wr_hit & (sel == SEL_CONTROL) & req_wdata_i[CT_START_BIT];
  assign stop_o  = wr_hit & (sel == SEL_CONTROL) & req_wdata_i[CT_STOP_BIT];

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      unique case (sel)
        SEL_STATUS: begin
          rd_mux[ST_TIMEOUT_BIT] = timeout_q;
          rd_mux[ST_RUNNING_BIT] = running_i;
        end
        SEL_CONTROL: begin
          rd_mux[CT_IRQ_EN_BIT] = ctrl_q.irq_en;
          rd_mux[CT_RELOAD_BIT] = ctrl_q.auto_reload;
        end
        SEL_PERIOD:   rd_mux = period_q;
        SEL_SNAPSHOT: rd_mux = count_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      period_q   <= '0;
      timeout_q  <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      if (wr_hit && sel == SEL_CONTROL) begin
        ctrl_q.irq_en      <= req_wdata_i[CT_IRQ_EN_BIT];
        ctrl_q.auto_reload <= req_wdata_i[CT_RELOAD_BIT];
      end
      if (load_o) period_q <= req_wdata_i;
      // hardware set beats software clear
      if (expire_i)                          timeout_q <= 1'b1;
      else if (wr_hit && sel == SEL_STATUS)  timeout_q <= 1'b0;
      rd_valid_o <= rd_hit;
      if (rd_hit) rd_data_o <= rd_mux;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign period_o  = period_q;
  assign timeout_o = timeout_q;

  assert_expire_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> timeout_o);

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && sel == SEL_STATUS && !expire_i) |=> !timeout_o);

  assert_rd_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> rd_valid_o);

  assert_rd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> !rd_valid_o);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] period, count;
  logic              load, start, stop, timeout, running, expire;

  itmr_regs #(.W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .expire_i(expire), .running_i(running), .count_i(count),
    .ctrl_o(ctrl), .period_o(period), .load_o(load), .start_o(start),
    .stop_o(stop), .timeout_o(timeout), .rd_valid_o, .rd_data_o
  );

  itmr_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .tick_en_i,
    .load_i(load), .load_val_i(req_wdata_i), .start_i(start), .stop_i(stop),
    .auto_reload_i(ctrl.auto_reload), .period_i(period),
    .count_o(count), .running_o(running), .expire_o(expire)
  );

  assign irq_o = timeout & ctrl.irq_en;

  assert_reload_runs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctrl.auto_reload && !stop && !load) |=> (running && count == $past(period)));

  assert_load_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> count == $past(req_wdata_i));
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  interval_timer #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, bit with_tick = 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; tick_en = with_tick;
    @(negedge clk);
    req_valid = 0; req_write = 0; tick_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (rd_valid !== 1'b1) begin
      fails++;
      $display("FAIL R9: rd_valid actual %0b expected 1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic expect_rd(string req, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic t_reset;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R9 idle rd_valid", {31'b0, rd_valid}, 32'h0);
    expect_rd("R1 status", 6'h00, 32'h0);
    expect_rd("R1 control", 6'h04, 32'h0);
    expect_rd("R1 period", 6'h08, 32'h0);
    expect_rd("R1 snapshot", 6'h0C, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(6'h08, 32'd5);
    expect_rd("R2 period", 6'h08, 32'd5);
    expect_rd("R2 snapshot", 6'h0C, 32'd5);
    ticks(2);
    expect_rd("R3 stopped hold", 6'h0C, 32'd5);
    wr(6'h04, 32'h4);
    expect_rd("R6 running", 6'h00, 32'h2);
    ticks(3);
    expect_rd("R3 decrement", 6'h0C, 32'd2);
    expect_rd("R3 no tick hold", 6'h0C, 32'd2);
    ticks(2);
    expect_rd("R4 status", 6'h00, 32'h1);
    expect_rd("R4 count zero", 6'h0C, 32'd0);
    check("R8 irq disabled", {31'b0, irq}, 32'h0);
    wr(6'h04, 32'h1);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h0);
    check("R7 irq after clear", {31'b0, irq}, 32'h0);
    expect_rd("R7 cleared", 6'h00, 32'h0);
  endtask

  task automatic t_reload;
    wr(6'h04, 32'h0);
    wr(6'h08, 32'd3);
    wr(6'h04, 32'h6);
    ticks(3);
    expect_rd("R5 reload status", 6'h00, 32'h3);
    expect_rd("R5 reload count", 6'h0C, 32'd3);
    ticks(1);
    expect_rd("R5 continues", 6'h0C, 32'd2);
    wr(6'h04, 32'h8);
    wr(6'h08, 32'd0);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'h6);
    ticks(1);
    expect_rd("R5 zero period", 6'h00, 32'h3);
    wr(6'h00, 32'h0);
    ticks(1);
    expect_rd("R5 zero period again", 6'h00, 32'h3);
  endtask

  task automatic t_commands;
    wr(6'h04, 32'h8);
    wr(6'h00, 32'h0);
    wr(6'h08, 32'd7);
    wr(6'h04, 32'hC);
    expect_rd("R6 stop wins", 6'h00, 32'h0);
    wr(6'h04, 32'hF);
    expect_rd("R6 readback", 6'h04, 32'h3);
    expect_rd("R6 not running", 6'h00, 32'h0);
    wr(6'h00, 32'h2);
    expect_rd("R6 run bit not writable", 6'h00, 32'h0);
  endtask

  task automatic t_collide;
    wr(6'h04, 32'h0);
    wr(6'h08, 32'd4);
    wr(6'h04, 32'h4);
    ticks(3);
    expect_rd("R3 pre collide", 6'h0C, 32'd1);
    wr(6'h00, 32'h0, 1);
    expect_rd("R7 expiry beats clear", 6'h00, 32'h1);
    wr(6'h00, 32'h0);
    wr(6'h08, 32'd9);
    wr(6'h04, 32'h4);
    wr(6'h08, 32'd20, 1);
    expect_rd("R11 load wins", 6'h0C, 32'd20);
    wr(6'h04, 32'h8);
  endtask

  task automatic t_unmapped;
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h09, 32'hFFFF_FFFF);
    wr(6'h0C, 32'h55);
    expect_rd("R10 period kept", 6'h08, 32'd20);
    expect_rd("R10 control kept", 6'h04, 32'h0);
    expect_rd("R10 snapshot kept", 6'h0C, 32'd20);
    expect_rd("R10 unmapped read", 6'h10, 32'h0);
    expect_rd("R10 misaligned read", 6'h09, 32'h0);
    @(negedge clk);
    check("R9 strobe drops", {31'b0, rd_valid}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_oneshot();
    t_reload();
    t_commands();
    t_collide();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule